// File: doc/BRIEF.md
# Selectable Audio Bit-Depth Reducer

This block is a streaming stereo-to-mono quantiser. Each accepted sample pair (left and right, 24-bit two's complement) is folded to one mono value with equal weight per channel. The mono value is then coarsened to one of eight word lengths, and the same coarsened value is driven onto both output channels. The reduction acts on the absolute value of the sample and puts the sign back afterwards. Because of this, every result rounds toward zero, and negative samples never flip polarity or grow in size.

A 24-bit control word travels alongside the data and is sampled in the same cycle. Only its three bits directly below the sign bit choose the word length. The datapath has one register stage: a sample presented with its valid strobe appears at the outputs one clock later with its own valid flag. Between samples the outputs hold their last value.

Top module: `bitcrush_top`

## Requirements
- R1: The mono value equals floor((left + right) / 2). The sum is formed in 25-bit signed arithmetic and cannot overflow, so left = right = 0x800000 yields 0x800000.
- R2: The word length is chosen by control bits [22:20], read as an unsigned index: 0→24, 1→16, 2→14, 3→12, 4→10, 5→8, 6→6, 7→4 bits. Control bit 23 and bits [19:0] have no effect on the output.
- R3: With index 0 (24 bits) the mono value is passed unchanged, including 0x800000.
- R4: For an N-bit setting and a non-negative mono value, the output keeps the top N bits of the 24-bit word and clears the lower 24−N bits. For example, 6 bits keeps only bits [23:18], so the mask is 0xFC0000. The mask always keeps bit 23.
- R5: For an N-bit setting and a negative mono value, the output is −((−x) with its lower 24−N bits cleared). The output is therefore never positive, and no output is further from zero than its input.
- R6: When the magnitude of 0x800000 is formed for reduction, it saturates to 0x7FFFFF. At 4 bits, 0x800000 gives 0x900000.
- R7: Both output channels always carry the same value.
- R8: out_valid is asserted in the cycle after the input strobe is accepted, and only then. The data on the outputs at that point is the result for that sample and its control word.
- R9: While in_valid is low, the output data holds its previous value.
- R10: Active-low reset clears both outputs to zero and deasserts out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_left | input | 24 | Left input sample, two's complement |
| in_right | input | 24 | Right input sample, two's complement |
| depth_ctrl | input | 24 | Control word; bits [22:20] select the word length |
| out_valid | output | 1 | Output valid, one cycle after in_valid |
| out_left | output | 24 | Reduced mono result, left channel |
| out_right | output | 24 | Reduced mono result, right channel |

## Verification
The bench targets small negative values such as −1 and −255. A design that masks the raw two's-complement word would turn these into large negative values instead of zero. It drives 0x800000 from both inputs: a magnitude path without saturation would wrap and produce a positive or garbage result, and a mixer that adds before halving in 24 bits would overflow. It scrambles the control bits outside [22:20] to expose a decoder that reads the wrong field or reads the steps in the wrong order. It also drops the strobe with changed data, to catch outputs that follow the inputs while they should hold.

// File: rtl/bitcrush_pkg.sv
package bitcrush_pkg;

    localparam int unsigned DEF_SAMPLE_W = 24;
    localparam int unsigned DEF_SEL_W    = 3;

    // Number of retained bits for a given step index.
    // Step 0 is full width; later steps shed two bits each, ending at four
    // bits for the last of eight steps.
    function automatic int unsigned keep_width(
        input int unsigned idx,
        input int unsigned width,
        input int unsigned steps
    );
        int unsigned k;
        if (idx == 0) begin
            k = width;
        end else begin
            k = 2 * (steps + 1) - 2 * idx;
        end
        if (k > width) begin
            k = width;
        end
        return k;
    endfunction

endpackage

// File: rtl/mono_mixer.sv
module mono_mixer #(
    parameter int unsigned W = 24
) (
    input  logic [W-1:0] left_i,
    input  logic [W-1:0] right_i,
    output logic [W-1:0] mono_o
);
    logic signed [W:0] sum_w;

    always_comb begin
        sum_w  = $signed({left_i[W-1], left_i}) + $signed({right_i[W-1], right_i});
        mono_o = sum_w[W:1];
    end
endmodule

// File: rtl/magnitude_splitter.sv
module magnitude_splitter #(
    parameter int unsigned W = 24
) (
    input  logic [W-1:0] sample_i,
    output logic         neg_o,
    output logic [W-1:0] mag_o
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

    always_comb begin
        neg_o = sample_i[W-1];
        if (!neg_o) begin
            mag_o = sample_i;
        end else if (sample_i == MOST_NEG) begin
            mag_o = MOST_POS;
        end else begin
            mag_o = ~sample_i + 1'b1;
        end
    end

    // The magnitude path must never carry a set sign bit (R6)
    always_comb begin
        assert_mag_nonneg_R6: assert (mag_o[W-1] == 1'b0)
            else $error("magnitude has sign bit set");
    end
endmodule

// File: rtl/depth_mask_gen.sv
module depth_mask_gen
    import bitcrush_pkg::*;
#(
    parameter int unsigned W     = 24,
    parameter int unsigned SEL_W = 3
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [W-1:0]     mask_o,
    output logic             bypass_o
);
    localparam int unsigned NSTEPS = 2 ** SEL_W;

    logic [31:0] keep_w;
    logic [31:0] lsb_cut;

    always_comb begin
        keep_w   = keep_width(32'(sel_i), W, NSTEPS);
        lsb_cut  = W - keep_w;
        bypass_o = (sel_i == '0);
    end

    for (genvar b = 0; b < W; b++) begin : g_mask_bit
        assign mask_o[b] = (32'(b) >= lsb_cut);
    end

    // The sign position is never cleared by the mask (R4)
    always_comb begin
        assert_sign_bit_kept_R4: assert (mask_o[W-1] == 1'b1)
            else $error("mask clears the sign position");
    end
endmodule

// File: rtl/sign_restorer.sv
module sign_restorer #(
    parameter int unsigned W = 24
) (
    input  logic         neg_i,
    input  logic [W-1:0] mag_i,
    output logic [W-1:0] value_o
);
    always_comb begin
        value_o = neg_i ? (~mag_i + 1'b1) : mag_i;
    end

    // A nonzero result keeps the sign of the original sample (R5)
    always_comb begin
        assert_sign_restored_R5: assert ((value_o == '0) || (value_o[W-1] == neg_i))
            else $error("restored sign differs from source sign");
    end
endmodule

// File: rtl/bitcrush_top.sv
module bitcrush_top
    import bitcrush_pkg::*;
#(
    parameter int unsigned W     = DEF_SAMPLE_W,
    parameter int unsigned SEL_W = DEF_SEL_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_left,
    input  logic [W-1:0] in_right,
    input  logic [W-1:0] depth_ctrl,
    output logic         out_valid,
    output logic [W-1:0] out_left,
    output logic [W-1:0] out_right
);
    localparam int unsigned SEL_HI = W - 2;
    localparam int unsigned SEL_LO = W - 1 - SEL_W;

    typedef struct packed {
        logic         vld;
        logic [W-1:0] left;
        logic [W-1:0] right;
    } out_state_t;

    out_state_t st_d, st_q;

    logic [SEL_W-1:0] step_sel;
    logic [W-1:0]     mono;
    logic             mono_neg;
    logic [W-1:0]     mono_mag;
    logic [W-1:0]     keep_mask;
    logic             full_width;
    logic [W-1:0]     mag_cut;
    logic [W-1:0]     signed_cut;
    logic [W-1:0]     crushed;

    wire ctrl_unused_bits = ^{depth_ctrl[W-1], depth_ctrl[SEL_LO-1:0]};

    assign step_sel = depth_ctrl[SEL_HI:SEL_LO];

    mono_mixer #(.W(W)) u_mix (
        .left_i  (in_left),
        .right_i (in_right),
        .mono_o  (mono)
    );

    magnitude_splitter #(.W(W)) u_split (
        .sample_i (mono),
        .neg_o    (mono_neg),
        .mag_o    (mono_mag)
    );

    depth_mask_gen #(.W(W), .SEL_W(SEL_W)) u_mask (
        .sel_i    (step_sel),
        .mask_o   (keep_mask),
        .bypass_o (full_width)
    );

    assign mag_cut = mono_mag & keep_mask;

    sign_restorer #(.W(W)) u_restore (
        .neg_i   (mono_neg),
        .mag_i   (mag_cut),
        .value_o (signed_cut)
    );

    always_comb begin
        crushed = full_width ? mono : signed_cut;
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.left  = crushed;
            st_d.right = crushed;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_left  = st_q.left;
    assign out_right = st_q.right;

    // Full-width step leaves the mono value untouched (R3)
    always_comb begin
        assert_bypass_exact_R3: assert (!(full_width && (crushed != mono)))
            else $error("full-width step altered the sample");
    end

    // Both channels always agree (R7)
    assert_channels_equal_R7: assert property (
        @(posedge clk) disable iff (!rst_n) out_left == out_right
    );

    // Output valid follows the input strobe by one cycle (R8)
    assert_valid_latency_R8: assert property (
        @(posedge clk) disable iff (!rst_n) $past(rst_n) |-> (out_valid == $past(in_valid))
    );

    // Output data holds when no sample was accepted (R9)
    assert_hold_idle_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(in_valid)) |-> ($stable(out_left) && $stable(out_right))
    );
endmodule

// File: tb/bitcrush_top_test.sv
`timescale 1ns/1ps
module bitcrush_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] in_left = '0;
    logic [23:0] in_right = '0;
    logic [23:0] depth_ctrl = '0;
    logic        out_valid;
    logic [23:0] out_left;
    logic [23:0] out_right;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bitcrush_top uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_left    (in_left),
        .in_right   (in_right),
        .depth_ctrl (depth_ctrl),
        .out_valid  (out_valid),
        .out_left   (out_left),
        .out_right  (out_right)
    );

    function automatic int bits_for(int idx);
        case (idx)
            0: return 24;
            1: return 16;
            2: return 14;
            3: return 12;
            4: return 10;
            5: return 8;
            6: return 6;
            default: return 4;
        endcase
    endfunction

    function automatic logic [23:0] f_mono(logic [23:0] l, logic [23:0] r);
        int li, ri, s;
        li = int'($signed(l));
        ri = int'($signed(r));
        s  = (li + ri) >>> 1;
        return s[23:0];
    endfunction

    function automatic logic [23:0] f_crush(logic [23:0] m, int idx);
        int v, mag, unit, nb;
        nb = bits_for(idx);
        if (nb == 24) return m;
        v    = int'($signed(m));
        mag  = (v < 0) ? -v : v;
        if (mag > 8388607) mag = 8388607;
        unit = 1 << (24 - nb);
        mag  = (mag / unit) * unit;
        v    = (v < 0) ? -mag : mag;
        return v[23:0];
    endfunction

    task automatic chk(string tag, logic [23:0] act, logic [23:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Present one sample at a falling edge, check at the next falling edge.
    task automatic step(string tag, logic [23:0] l, logic [23:0] r, logic [23:0] ctrl);
        logic [23:0] e;
        int idx;
        idx = int'(ctrl[22:20]);
        e = f_crush(f_mono(l, r), idx);
        in_valid   = 1'b1;
        in_left    = l;
        in_right   = r;
        depth_ctrl = ctrl;
        @(negedge clk);
        chk({tag, " R8 valid"}, {23'd0, out_valid}, 24'd1);
        chk({tag, " left"}, out_left, e);
        chk({tag, " R7 right"}, out_right, e);
    endtask

    function automatic logic [23:0] ctl(int idx);
        return {1'b0, 3'(idx), 20'd0};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [23:0] held;
        seed = 1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 reset valid", {23'd0, out_valid}, 24'd0);
        chk("R10 reset left", out_left, 24'd0);
        chk("R10 reset right", out_right, 24'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: mixing, including extreme pairs
        step("R1 mix pos", 24'h100000, 24'h300000, ctl(0));
        step("R1 mix odd", 24'h000003, 24'h000000, ctl(0));
        step("R1 mix negodd", 24'hFFFFFD, 24'h000000, ctl(0));
        step("R1 mix maxpos", 24'h7FFFFF, 24'h7FFFFF, ctl(0));
        // R3: full width passes 0x800000 unchanged
        step("R3 bypass mostneg", 24'h800000, 24'h800000, ctl(0));
        chk("R3 value", out_left, 24'h800000);

        // R4: positive masking at each step
        for (int i = 1; i < 8; i++) step("R4 pos mask", 24'h7FFFFF, 24'h7FFFFF, ctl(i));
        step("R4 six bit", 24'h7FFFFF, 24'h7FFFFF, ctl(6));
        chk("R4 six bit literal", out_left, 24'h7C0000);

        // R5: small negatives truncate toward zero
        step("R5 minus one", 24'hFFFFFF, 24'hFFFFFF, ctl(1));
        chk("R5 minus one zero", out_left, 24'h000000);
        step("R5 minus 255", 24'hFFFF01, 24'hFFFF01, ctl(1));
        chk("R5 minus 255 zero", out_left, 24'h000000);
        step("R5 minus 256", 24'hFFFF00, 24'hFFFF00, ctl(1));
        chk("R5 minus 256 kept", out_left, 24'hFFFF00);
        for (int i = 1; i < 8; i++) step("R5 neg mask", 24'hABCDEF, 24'hABCDEF, ctl(i));

        // R6: most negative saturates before masking
        step("R6 sat", 24'h800000, 24'h800000, ctl(7));
        chk("R6 sat literal", out_left, 24'h900000);

        // R2: unused control bits ignored, step order honoured
        for (int i = 0; i < 8; i++) begin
            logic [23:0] c;
            c = $urandom();
            c[22:20] = 3'(i);
            step("R2 ctrl noise", 24'h2468AC, 24'hF13579, c);
        end
        step("R2 order 4bit", 24'h345678, 24'h345678, {1'b1, 3'd7, 20'hFFFFF});
        chk("R2 order 4bit literal", out_left, 24'h300000);

        // R9: hold while idle
        held = out_left;
        in_valid = 1'b0;
        in_left = 24'h111111;
        in_right = 24'h222222;
        depth_ctrl = ctl(3);
        @(negedge clk);
        chk("R8 idle valid", {23'd0, out_valid}, 24'd0);
        chk("R9 hold left", out_left, held);
        chk("R9 hold right", out_right, held);
        @(negedge clk);
        chk("R9 hold again", out_left, held);

        // Random traffic across R1 to R7
        for (int n = 0; n < 2000; n++) begin
            step("R1-random", $urandom(), $urandom(), $urandom());
        end

        // R10: reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 midrun valid", {23'd0, out_valid}, 24'd0);
        chk("R10 midrun data", out_left, 24'd0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule